// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a memory device. It is clocked by a test clock. It runs the standard sixteen-state test controller, steered by a mode-select line. It holds a small instruction register, a single-bit bypass stage and a boundary register whose length is a parameter. Depending on the instruction in force, either the instruction register, the bypass stage or the boundary register is placed between the serial input and the serial output.

The boundary register observes the device pins. Cells wired to a pin take the pin level when data is captured. Cells with no pin take a per-cell constant instead. The pin-driving instruction observes the pins but never overrides them: the core always sees the real pin levels. Values shifted into the boundary register are copied to a parallel update stage, which is only visible on an output port and has no effect on the core. The reset input is synchronous to the test clock and active low.

Top module: `scan_tap_top`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the controller enters Test-Logic-Reset. At the following falling edge, `tdo_oe` and `tdo` go to 0, `ir_current` goes to all ones and `bsr_update` goes to 0.
- R2: The controller steps through its sixteen states on rising `tck` edges, steered by `tms`. Five consecutive rising edges with `tms` high always reach Test-Logic-Reset, and that state loads the all-ones code into `ir_current` at the next falling edge.
- R3: `tdo_oe` changes only on falling `tck` edges. It is 1 only while the controller is in Shift-IR or Shift-DR. In every other state `tdo` is driven 0.
- R4: Capture-IR loads the instruction shift stage with bit 0 = 1 and all other bits 0. Shift-IR moves that stage one bit towards bit 0 per rising edge, with `tdi` entering the MSB, and `tdo` shows bit 0.
- R5: In Update-IR, the falling edge copies the instruction shift stage into `ir_current`. In every other state `ir_current` holds its value.
- R6: Instruction decode: code 0 selects the pin-driving (observe-only) mode, `SAMPLE_CODE` (default 3'b010) selects sample/preload, and all ones selects bypass. Every other code also behaves as bypass.
- R7: Under bypass, Capture-DR clears the bypass bit and Shift-DR passes `tdi` to `tdo` with a delay of one stage.
- R8: Under the two boundary modes, Capture-DR loads cell i from `pin_in[i]` for i < `PIN_CNT`, and from `CELL_DEFAULT[i]` for the remaining cells. Shift-DR then shifts the cells out on `tdo`, cell 0 first, with `tdi` entering the top cell.
- R9: Under the two boundary modes, the falling edge in Update-DR copies the boundary shift stage into `bsr_update`. Under any other instruction, `bsr_update` keeps its value.
- R10: `core_in` always equals `pin_in`, whatever the instruction, including the pin-driving mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| pin_in | input | PIN_CNT | Device pin levels observed by the boundary register |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Serial output valid / enable |
| ir_current | output | IR_W | Instruction in force |
| bsr_update | output | BSR_LEN | Parallel update stage of the boundary register |
| core_in | output | PIN_CNT | Pin levels as seen by the functional core |

## Verification
Two things can fall in the same cycle. A reset, either by `trst_n` or by five high `tms` cycles, can land in the middle of a Shift-DR burst. The pins can also change one cycle after a capture, while shifting is in progress and while the pin-driving mode is active. The bench provokes both: it drops `trst_n` partway through a boundary shift, forces five high `tms` cycles out of Shift-IR, and changes `pin_in` during Shift-DR. A behavioural reference model is stepped on both clock edges and compared on every cycle with `tdo`, `tdo_oe`, `ir_current`, `bsr_update` and `core_in`. This confirms that the abort wins, that the update stage is left untouched, and that the core keeps seeing live pin values.

// File: rtl/tap_scan_pkg.sv
// Package: shared controller state encoding for the scan port.
// Assumes: the state values are used only inside this block.
package tap_scan_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SHF_DR,
        TS_EX1_DR,
        TS_PAU_DR,
        TS_EX2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SHF_IR,
        TS_EX1_IR,
        TS_PAU_IR,
        TS_EX2_IR,
        TS_UPD_IR
    } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
// Module: sixteen-state test controller. Advances on rising tck, steered by tms.
// Assumes: trst_n is synchronous to tck and active low.
module tap_fsm
    import tap_scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Purpose: next-state selection from the current state and tms.
    always_comb begin
        case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    // Purpose: state register with synchronous reset into Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    // Checker support: count consecutive high tms samples, saturating at five.
    logic [2:0] hi_run;
    always_ff @(posedge tck) begin
        if (!trst_n)             hi_run <= 3'd0;
        else if (!tms)           hi_run <= 3'd0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    // R2: five high tms samples in a row always leave the controller in Test-Logic-Reset
    p_five_high_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/tap_ir.sv
// Module: instruction shift stage, instruction in force, and decode.
// Assumes: IR_W >= 2. The instruction is updated on falling tck in Update-IR,
// and is forced to bypass while in Test-Logic-Reset.
module tap_ir
    import tap_scan_pkg::*;
#(
    parameter int              IR_W        = 3,
    parameter logic [IR_W-1:0] SAMPLE_CODE = 3'b010
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_sout,
    output logic            use_bsr
);

    localparam logic [IR_W-1:0] CAP_PAT    = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [IR_W-1:0] CODE_BYP   = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] CODE_EXTST = {IR_W{1'b0}};

    logic [IR_W-1:0] ir_sr;

    // Purpose: capture the fixed pattern, or shift towards bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= '0;
        else if (state == TS_CAP_IR) ir_sr <= CAP_PAT;
        else if (state == TS_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Purpose: instruction in force, loaded on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n)                 ir_q <= CODE_BYP;
        else if (state == TS_RESET)  ir_q <= CODE_BYP;
        else if (state == TS_UPD_IR) ir_q <= ir_sr;
    end

    // Purpose: serial output bit and decode of the two boundary modes.
    always_comb begin
        ir_sout = ir_sr[0];
        use_bsr = (ir_q == CODE_EXTST) || (ir_q == SAMPLE_CODE);
    end

    // R4: Capture-IR always leaves 01 in the two low bits
    p_cap_pattern_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

    // R5: the instruction in force only moves at the falling edge of Update-IR or Test-Logic-Reset
    p_ir_hold_r5: assert property (@(negedge tck) disable iff (!trst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/tap_bsr.sv
// Module: boundary register with capture, shift and a parallel update stage.
// Assumes: pins are stable around the capture edge. Cells PIN_CNT and above
// have no pin and capture CELL_DEFAULT.
module tap_bsr
    import tap_scan_pkg::*;
#(
    parameter int                 BSR_LEN      = 10,
    parameter int                 PIN_CNT      = 7,
    parameter logic [BSR_LEN-1:0] CELL_DEFAULT = '0
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  logic               use_bsr,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               bsr_sout,
    output logic [BSR_LEN-1:0] upd_q
);

    logic [BSR_LEN-1:0] cap_vec;
    logic [BSR_LEN-1:0] sr;

    // Purpose: choose a pin or the fixed default for each cell.
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        if (i < PIN_CNT) begin : g_pin
            assign cap_vec[i] = pin_in[i];
        end else begin : g_fixed
            assign cap_vec[i] = CELL_DEFAULT[i];
        end
    end

    // Purpose: capture or shift the boundary cells when they are selected.
    always_ff @(posedge tck) begin
        if (!trst_n)                            sr <= '0;
        else if (use_bsr && state == TS_CAP_DR) sr <= cap_vec;
        else if (use_bsr && state == TS_SHF_DR) sr <= {tdi, sr[BSR_LEN-1:1]};
    end

    // Purpose: parallel update stage, loaded on the falling edge of Update-DR.
    always_ff @(negedge tck) begin
        if (!trst_n)                            upd_q <= '0;
        else if (use_bsr && state == TS_UPD_DR) upd_q <= sr;
    end

    assign bsr_sout = sr[0];

    // R9: the update stage is left alone unless a boundary mode is in Update-DR
    p_upd_hold_r9: assert property (@(negedge tck) disable iff (!trst_n)
        !(use_bsr && state == TS_UPD_DR) |=> $stable(upd_q));

endmodule

// File: rtl/scan_tap_top.sv
// Module: test port top. Holds the controller, instruction, bypass and boundary
// registers, and the serial output stage driven on falling tck.
// Assumes: the functional core takes core_in, which is never gated.
module scan_tap_top
    import tap_scan_pkg::*;
#(
    parameter int                 IR_W         = 3,
    parameter logic [IR_W-1:0]    SAMPLE_CODE  = 3'b010,
    parameter int                 BSR_LEN      = 10,
    parameter int                 PIN_CNT      = 7,
    parameter logic [BSR_LEN-1:0] CELL_DEFAULT = 10'b10_1000_0000
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [IR_W-1:0]    ir_current,
    output logic [BSR_LEN-1:0] bsr_update,
    output logic [PIN_CNT-1:0] core_in
);

    tap_state_e state;
    logic       ir_sout;
    logic       use_bsr;
    logic       bsr_sout;
    logic       byp_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir #(.IR_W(IR_W), .SAMPLE_CODE(SAMPLE_CODE)) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .ir_q    (ir_current),
        .ir_sout (ir_sout),
        .use_bsr (use_bsr)
    );

    tap_bsr #(.BSR_LEN(BSR_LEN), .PIN_CNT(PIN_CNT), .CELL_DEFAULT(CELL_DEFAULT)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (state),
        .use_bsr  (use_bsr),
        .pin_in   (pin_in),
        .bsr_sout (bsr_sout),
        .upd_q    (bsr_update)
    );

    // Purpose: single-bit bypass stage, cleared at capture and shifting otherwise.
    always_ff @(posedge tck) begin
        if (!trst_n)                             byp_q <= 1'b0;
        else if (!use_bsr && state == TS_CAP_DR) byp_q <= 1'b0;
        else if (!use_bsr && state == TS_SHF_DR) byp_q <= tdi;
    end

    // Purpose: serial output and its enable, updated on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            case (state)
                TS_SHF_IR: begin
                    tdo    <= ir_sout;
                    tdo_oe <= 1'b1;
                end
                TS_SHF_DR: begin
                    tdo    <= use_bsr ? bsr_sout : byp_q;
                    tdo_oe <= 1'b1;
                end
                default: begin
                    tdo    <= 1'b0;
                    tdo_oe <= 1'b0;
                end
            endcase
        end
    end

    // Purpose: the core always sees live pin levels, whatever the instruction.
    assign core_in = pin_in;

    // R3: the output enable is only seen while a shift state is in force
    p_oe_shift_only_r3: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == TS_SHF_IR || state == TS_SHF_DR));

    // R7: bypass capture clears the bypass stage
    p_byp_capture_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (!use_bsr && state == TS_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: tb/scan_tap_top_tb.sv
`timescale 1ns/1ps
module scan_tap_top_tb;

    localparam int                 IR_W   = 3;
    localparam logic [IR_W-1:0]    SCODE  = 3'b010;
    localparam int                 LEN    = 10;
    localparam int                 PINS   = 7;
    localparam logic [LEN-1:0]     DEFS   = 10'b10_1000_0000;

    // Reference-model state numbering (behavioural, bench-only)
    localparam int M_RESET = 0, M_IDLE = 1, M_SELDR = 2, M_CAPDR = 3, M_SHFDR = 4,
                   M_EX1DR = 5, M_PAUDR = 6, M_EX2DR = 7, M_UPDDR = 8, M_SELIR = 9,
                   M_CAPIR = 10, M_SHFIR = 11, M_EX1IR = 12, M_PAUIR = 13,
                   M_EX2IR = 14, M_UPDIR = 15;

    logic            tck = 1'b0;
    logic            trst_n = 1'b0;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic [PINS-1:0] pin_in = '0;
    logic            tdo;
    logic            tdo_oe;
    logic [IR_W-1:0] ir_current;
    logic [LEN-1:0]  bsr_update;
    logic [PINS-1:0] core_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 tck = ~tck;

    scan_tap_top #(.IR_W(IR_W), .SAMPLE_CODE(SCODE), .BSR_LEN(LEN),
                   .PIN_CNT(PINS), .CELL_DEFAULT(DEFS)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .ir_current(ir_current),
        .bsr_update(bsr_update), .core_in(core_in)
    );

    // Reference model
    int              m_st = M_RESET;
    logic [IR_W-1:0] m_irsr = '0;
    logic [IR_W-1:0] m_cur = '1;
    logic [LEN-1:0]  m_bsr = '0;
    logic [LEN-1:0]  m_upd = '0;
    logic            m_byp = 1'b0;
    logic            m_tdo = 1'b0;
    logic            m_oe = 1'b0;
    string           m_tag = "R3";

    function automatic int next_st(int s, logic t);
        case (s)
            M_RESET: return t ? M_RESET : M_IDLE;
            M_IDLE:  return t ? M_SELDR : M_IDLE;
            M_SELDR: return t ? M_SELIR : M_CAPDR;
            M_CAPDR, M_SHFDR: return t ? M_EX1DR : M_SHFDR;
            M_EX1DR: return t ? M_UPDDR : M_PAUDR;
            M_PAUDR: return t ? M_EX2DR : M_PAUDR;
            M_EX2DR: return t ? M_UPDDR : M_SHFDR;
            M_UPDDR, M_UPDIR: return t ? M_SELDR : M_IDLE;
            M_SELIR: return t ? M_RESET : M_CAPIR;
            M_CAPIR, M_SHFIR: return t ? M_EX1IR : M_SHFIR;
            M_EX1IR: return t ? M_UPDIR : M_PAUIR;
            M_PAUIR: return t ? M_EX2IR : M_PAUIR;
            M_EX2IR: return t ? M_UPDIR : M_SHFIR;
            default: return M_RESET;
        endcase
    endfunction

    function automatic bit boundary_mode(logic [IR_W-1:0] c);
        return (c == '0) || (c == SCODE);
    endfunction

    task automatic model_rise();
        bit bm;
        bm = boundary_mode(m_cur);
        if (!trst_n) begin
            m_st = M_RESET; m_irsr = '0; m_bsr = '0; m_byp = 1'b0;
        end else begin
            if (m_st == M_CAPIR) m_irsr = 1;
            if (m_st == M_SHFIR) m_irsr = {tdi, m_irsr[IR_W-1:1]};
            if (m_st == M_CAPDR) begin
                if (bm) for (int i = 0; i < LEN; i++) m_bsr[i] = (i < PINS) ? pin_in[i] : DEFS[i];
                else m_byp = 1'b0;
            end
            if (m_st == M_SHFDR) begin
                if (bm) m_bsr = {tdi, m_bsr[LEN-1:1]};
                else m_byp = tdi;
            end
            m_st = next_st(m_st, tms);
        end
    endtask

    task automatic model_fall();
        bit bm;
        bm = boundary_mode(m_cur);
        if (!trst_n) begin
            m_cur = '1; m_upd = '0; m_tdo = 1'b0; m_oe = 1'b0; m_tag = "R1";
        end else begin
            m_oe = (m_st == M_SHFIR || m_st == M_SHFDR);
            if (m_st == M_SHFIR) begin
                m_tdo = m_irsr[0]; m_tag = "R4";
            end else if (m_st == M_SHFDR) begin
                m_tdo = bm ? m_bsr[0] : m_byp;
                m_tag = bm ? "R8" : ((m_cur == '1) ? "R7" : "R6");
            end else begin
                m_tdo = 1'b0; m_tag = "R3";
            end
            if (m_st == M_UPDDR && bm) m_upd = m_bsr;
            if (m_st == M_RESET) m_cur = '1;
            else if (m_st == M_UPDIR) m_cur = m_irsr;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", "tdo_oe", 32'(tdo_oe), 32'(m_oe));
        chk(m_tag, "tdo", 32'(tdo), 32'(m_tdo));
        chk("R5", "ir_current", 32'(ir_current), 32'(m_cur));
        chk("R9", "bsr_update", 32'(bsr_update), 32'(m_upd));
        chk("R10", "core_in", 32'(core_in), 32'(pin_in));
    endtask

    // One tck cycle: drive, step model on both edges, compare after falling edge.
    task automatic step(logic t, logic d);
        tms = t; tdi = d;
        @(posedge tck); model_rise();
        @(negedge tck); model_fall();
        #1 compare_all();
    endtask

    // From Run-Test/Idle: load an instruction and return to Run-Test/Idle.
    task automatic load_ir(logic [IR_W-1:0] code);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < IR_W; i++) step(i == IR_W - 1, code[i]);
        step(1, 0); step(0, 0);
    endtask

    // From Run-Test/Idle: shift n bits through the data path, update, return to idle.
    task automatic shift_dr(int n, logic [31:0] data, bit with_pause);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            if (with_pause && i == n / 2) begin
                step(1, data[i]); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end else begin
                step(i == n - 1, data[i]);
            end
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [LEN-1:0] held;

    initial begin
        #1;
        // R1: reset state
        trst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1, 0);
        chk("R1", "reset tdo_oe", 32'(tdo_oe), 0);
        chk("R1", "reset ir_current", 32'(ir_current), 32'h7);
        chk("R1", "reset bsr_update", 32'(bsr_update), 0);
        trst_n = 1'b1;
        step(0, 0);

        // R6/R8/R9: sample mode, capture pins and defaults, pause mid-shift
        load_ir(SCODE);
        chk("R5", "ir after sample load", 32'(ir_current), 32'(SCODE));
        pin_in = 7'h5A;
        shift_dr(LEN, 32'h2C7, 1'b1);
        chk("R9", "update after sample", 32'(bsr_update), 32'h2C7);

        // R6/R10: pin-driving mode; pins change during shift, core still follows
        load_ir(3'b000);
        pin_in = 7'h13;
        step(1, 0); step(0, 0); step(0, 0);
        pin_in = 7'h6C;
        for (int i = 0; i < LEN; i++) step(i == LEN - 1, 1'(32'h135 >> i));
        step(1, 0); step(0, 0);
        chk("R9", "update after extest", 32'(bsr_update), 32'h135);
        chk("R10", "core during extest", 32'(core_in), 32'h6C);

        // R7: bypass mode, update stage untouched
        held = bsr_update;
        load_ir(3'b111);
        shift_dr(8, 32'hB5, 1'b0);
        chk("R9", "update held in bypass", 32'(bsr_update), 32'(held));

        // R6: undecoded code behaves as bypass
        load_ir(3'b101);
        chk("R6", "undecoded code held", 32'(ir_current), 32'h5);
        shift_dr(6, 32'h2D, 1'b0);
        chk("R6", "update held for undecoded", 32'(bsr_update), 32'(held));

        // R2: five high tms from Shift-IR force bypass
        load_ir(SCODE);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R2", "ir after five high", 32'(ir_current), 32'h7);
        chk("R2", "oe after five high", 32'(tdo_oe), 0);
        step(0, 0);

        // R1: reset dropped in the middle of a boundary shift
        load_ir(SCODE);
        pin_in = 7'h2B;
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 1); step(0, 0);
        trst_n = 1'b0;
        step(0, 1);
        chk("R1", "mid-shift reset oe", 32'(tdo_oe), 0);
        chk("R1", "mid-shift reset ir", 32'(ir_current), 32'h7);
        trst_n = 1'b1;
        step(0, 0); step(0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule